// File: doc/BRIEF.md
# Vector Lane Duplicate Finder

This block scans a source vector of up to 512 bits for repeated lane values. Lane width is 32 or 64 bits. Vector length is 128, 256 or 512 bits. Each output lane is a bitmap: bit k of lane j is set when lane j holds the same value as a lower-numbered lane k. The bitmap is zero-extended to the lane width.

A per-lane writemask then picks, for each lane, one of three results:
- the computed bitmap;
- a prior destination lane supplied on an input port (merge mode);
- zero (zero mode).

A broadcast option replaces the vector with one scalar copied into every lane.

Requests arrive through a valid/ready handshake. A two-state controller governs the result register:
- **ST_EMPTY**: no result is held.
- **ST_FULL**: a result is presented with `out_valid`.

The controller has four named transitions:
- **ACCEPT** (ST_EMPTY to ST_FULL): a request is taken.
- **STALL** (ST_FULL to ST_FULL): the result is held because `out_ready` is low.
- **REFILL** (ST_FULL to ST_FULL): the result drains and a new request is taken in the same cycle.
- **DRAIN** (ST_FULL to ST_EMPTY): the result is consumed and no new request is waiting.

Top module: `lane_dup_finder`

## Requirements
- R1: With 32-bit lanes (`in_lsz`=0), bit k of output lane j (k<j) is 1 exactly when source lanes j and k are equal.
- R2: In every computed lane j, bits j and above are 0, so computed lane 0 is all zero.
- R3: With 64-bit lanes (`in_lsz`=1), equality uses the whole 64-bit lane. Lanes that match only in one 32-bit half do not conflict.
- R4: `in_vl` selects 128 (0), 256 (1) or 512 (2) bits. This gives 4, 8 or 16 lanes at 32 bits and 2, 4 or 8 lanes at 64 bits.
- R5: When `in_mask_en`=1, `in_merge`=1 and a lane's mask bit is 0, that lane of the output equals the same lane of `in_prior`.
- R6: When `in_mask_en`=1, `in_merge`=0 and a lane's mask bit is 0, that lane is all zero.
- R7: When `in_mask_en`=0 every lane is computed. Mask bits at or above the lane count never affect the result.
- R8: All output bits above the selected vector length are 0.
- R9: With `in_bcast`=1, the low 32 or 64 bits of `in_src` are copied into every lane. Each computed lane j then has bits 0..j-1 set.
- R10: A request is accepted when `in_valid` and `in_ready` are both high. `out_valid` rises the next cycle, and the result stays stable until `out_ready`. `in_ready` is high when no result is held or `out_ready` is high.
- R11: An `in_lsz` of 2 or 3, or an `in_vl` of 3, sets `out_err` and gives an all-zero `out_data`. Otherwise `out_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_src | input | 512 | Source vector, or scalar in the low bits when broadcasting |
| in_prior | input | 512 | Prior destination value, used for merged lanes |
| in_mask | input | 16 | Per-lane writemask |
| in_mask_en | input | 1 | 1: apply the writemask |
| in_merge | input | 1 | 1: merge masked-off lanes, 0: zero them |
| in_bcast | input | 1 | 1: broadcast the low scalar to all lanes |
| in_lsz | input | 2 | Lane size: 0 = 32-bit, 1 = 64-bit |
| in_vl | input | 2 | Vector length: 0 = 128, 1 = 256, 2 = 512 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed |
| out_data | output | 512 | Masked result vector |
| out_err | output | 1 | Unsupported lane-size or length code |

## Verification
Two events can fall in the same cycle: the consumer drains a held result, and a new request is accepted. This is the REFILL transition. The bench provokes it by stalling `out_ready` while a second request waits on `in_valid`, then raising `out_ready`. Over the stall the bench expects the first result to stay unchanged. On the edge where `out_ready` rises, the second result must replace the first with no empty cycle between them.

// File: rtl/lane_dup_pkg.sv
package lane_dup_pkg;
    localparam logic [1:0] LSZ_W32 = 2'd0;
    localparam logic [1:0] LSZ_W64 = 2'd1;
    localparam logic [1:0] VL_BAD  = 2'd3;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ctrl_st_e;
endpackage

// File: rtl/lane_dup_cmp.sv
module lane_dup_cmp #(
    parameter int VEC_W = 512
) (
    input  logic [VEC_W-1:0] src,
    input  logic             bcast,
    input  logic             wide,
    output logic [VEC_W-1:0] raw
);
    localparam int D_LANES = VEC_W / 32;
    localparam int Q_LANES = VEC_W / 64;

    logic [VEC_W-1:0] dv, qv, draw, qraw;

    assign dv = bcast ? {D_LANES{src[31:0]}} : src;
    assign qv = bcast ? {Q_LANES{src[63:0]}} : src;

    for (genvar j = 0; j < D_LANES; j++) begin : g_dl
        for (genvar k = 0; k < 32; k++) begin : g_db
            if (k < j) begin : g_cmp
                assign draw[j*32+k] = (dv[j*32+:32] == dv[k*32+:32]);
            end else begin : g_zero
                assign draw[j*32+k] = 1'b0;
            end
        end
    end

    for (genvar j = 0; j < Q_LANES; j++) begin : g_ql
        for (genvar k = 0; k < 64; k++) begin : g_qb
            if (k < j) begin : g_cmp
                assign qraw[j*64+k] = (qv[j*64+:64] == qv[k*64+:64]);
            end else begin : g_zero
                assign qraw[j*64+k] = 1'b0;
            end
        end
    end

    assign raw = wide ? qraw : draw;
endmodule

// File: rtl/lane_dup_mask.sv
module lane_dup_mask #(
    parameter int VEC_W = 512,
    localparam int MASK_W = VEC_W / 32
) (
    input  logic [VEC_W-1:0]  raw,
    input  logic [VEC_W-1:0]  prior,
    input  logic [MASK_W-1:0] mask,
    input  logic              mask_en,
    input  logic              merge,
    input  logic              wide,
    input  logic [1:0]        vl,
    output logic [VEC_W-1:0]  res
);
    logic [5:0] lanes;

    always_comb begin
        lanes = (wide ? 6'd2 : 6'd4) << vl;
        res   = '0;
        for (int d = 0; d < MASK_W; d++) begin
            int lane;
            lane = wide ? (d / 2) : d;
            if (lane < int'(lanes)) begin
                if (!mask_en || mask[lane]) begin
                    res[d*32+:32] = raw[d*32+:32];
                end else if (merge) begin
                    res[d*32+:32] = prior[d*32+:32];
                end
            end
        end
    end
endmodule

// File: rtl/lane_dup_ctrl.sv
module lane_dup_ctrl
    import lane_dup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    ctrl_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (in_valid) st_d = ST_FULL;                 // ACCEPT
            ST_FULL:  if (out_ready) st_d = in_valid ? ST_FULL      // REFILL
                                                     : ST_EMPTY;    // DRAIN
            default:  st_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_EMPTY: begin in_ready = 1'b1;      out_valid = 1'b0; end
            ST_FULL:  begin in_ready = out_ready; out_valid = 1'b1; end
            default:  begin in_ready = 1'b0;      out_valid = 1'b0; end
        endcase
        load = in_valid && in_ready;
    end
endmodule

// File: rtl/lane_dup_finder.sv
module lane_dup_finder
    import lane_dup_pkg::*;
#(
    parameter int VEC_W = 512,
    localparam int MASK_W = VEC_W / 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VEC_W-1:0]  in_src,
    input  logic [VEC_W-1:0]  in_prior,
    input  logic [MASK_W-1:0] in_mask,
    input  logic              in_mask_en,
    input  logic              in_merge,
    input  logic              in_bcast,
    input  logic [1:0]        in_lsz,
    input  logic [1:0]        in_vl,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [VEC_W-1:0]  out_data,
    output logic              out_err
);
    logic             load, wide, bad;
    logic [VEC_W-1:0] raw, masked;
    logic [VEC_W-1:0] data_q;
    logic             err_q;

    assign wide = (in_lsz == LSZ_W64);
    assign bad  = (in_lsz != LSZ_W32 && in_lsz != LSZ_W64) || (in_vl == VL_BAD);

    lane_dup_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
        .in_ready(in_ready), .out_valid(out_valid), .load(load)
    );

    lane_dup_cmp #(.VEC_W(VEC_W)) cmp_i (
        .src(in_src), .bcast(in_bcast), .wide(wide), .raw(raw)
    );

    lane_dup_mask #(.VEC_W(VEC_W)) mask_i (
        .raw(raw), .prior(in_prior), .mask(in_mask), .mask_en(in_mask_en),
        .merge(in_merge), .wide(wide), .vl(in_vl), .res(masked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            err_q  <= 1'b0;
        end else if (load) begin
            data_q <= bad ? '0 : masked;
            err_q  <= bad;
        end
    end

    assign out_data = data_q;
    assign out_err  = err_q;
endmodule

// File: rtl/lane_dup_chk.sv
module lane_dup_chk #(
    parameter int VEC_W = 512,
    localparam int MASK_W = VEC_W / 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [MASK_W-1:0] in_mask,
    input logic              in_mask_en,
    input logic [1:0]        in_vl,
    input logic              out_valid,
    input logic              out_ready,
    input logic [VEC_W-1:0]  out_data,
    input logic              out_err
);
    logic [1:0]       cap_vl;
    logic             cap_l0;
    logic [VEC_W-1:0] keep;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vl <= 2'd0;
            cap_l0 <= 1'b0;
        end else if (in_valid && in_ready) begin
            cap_vl <= in_vl;
            cap_l0 <= !in_mask_en || in_mask[0];
        end
    end

    always_comb begin
        keep = '0;
        for (int b = 0; b < VEC_W; b++) keep[b] = (b < (128 << cap_vl));
    end

    a_r10_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));
    a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    a_r11_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_data == '0));
    a_r2_lane0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err && cap_l0) |-> (out_data[31:0] == 32'd0));
    a_r8_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> ((out_data & ~keep) == '0));
endmodule

bind lane_dup_finder lane_dup_chk #(.VEC_W(VEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_mask_en(in_mask_en), .in_vl(in_vl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_err(out_err)
);

// File: tb/lane_dup_finder_tb_top.sv
module lane_dup_finder_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [511:0] in_src = '0;
    logic [511:0] in_prior = '0;
    logic [15:0]  in_mask = '0;
    logic         in_mask_en = 1'b0;
    logic         in_merge = 1'b0;
    logic         in_bcast = 1'b0;
    logic [1:0]   in_lsz = 2'd0;
    logic [1:0]   in_vl = 2'd0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [511:0] out_data;
    logic         out_err;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    lane_dup_finder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_prior(in_prior), .in_mask(in_mask),
        .in_mask_en(in_mask_en), .in_merge(in_merge), .in_bcast(in_bcast),
        .in_lsz(in_lsz), .in_vl(in_vl), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_err(out_err)
    );

    function automatic logic [511:0] model(input logic [1:0] lsz, input logic [1:0] vl,
                                           input logic men, input logic mrg, input logic bc,
                                           input logic [511:0] src, input logic [511:0] prior,
                                           input logic [15:0] mask);
        logic [511:0] r;
        logic [63:0]  vj, vk;
        int lw, kl;
        r = '0;
        if (lsz > 2'd1 || vl == 2'd3) return r;
        lw = (lsz == 2'd1) ? 64 : 32;
        kl = (128 << vl) / lw;
        for (int j = 0; j < kl; j++) begin
            if (!men || mask[j]) begin
                for (int k = 0; k < j; k++) begin
                    if (lw == 64) begin
                        vj = bc ? src[63:0] : src[j*64+:64];
                        vk = bc ? src[63:0] : src[k*64+:64];
                    end else begin
                        vj = {32'd0, bc ? src[31:0] : src[j*32+:32]};
                        vk = {32'd0, bc ? src[31:0] : src[k*32+:32]};
                    end
                    r[j*lw+k] = (vj == vk);
                end
            end else if (mrg) begin
                for (int b = 0; b < lw; b++) r[j*lw+b] = prior[j*lw+b];
            end
        end
        return r;
    endfunction

    function automatic logic [511:0] pattern(input int p);
        logic [511:0] v;
        for (int d = 0; d < 16; d++) begin
            case (p)
                0: v[d*32+:32] = 32'(d) + 32'h100;
                1: v[d*32+:32] = 32'hA5A5_0001;
                2: v[d*32+:32] = 32'(d % 3);
                3: v[d*32+:32] = 32'(d / 2);
                4: v[d*32+:32] = (d % 2 == 0) ? 32'h7 : 32'(d);   // equal low halves only
                5: v[d*32+:32] = 32'h1000_0000 + 32'((d * 5) % 4);
                default: v[d*32+:32] = (d % 2 == 1) ? 32'h3 : 32'(d / 4);
            endcase
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [511:0] act,
                         input logic [511:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request with out_ready high: accept, check, drain.
    task automatic run_one(input logic [1:0] lsz, input logic [1:0] vl, input logic men,
                           input logic mrg, input logic bc, input logic [511:0] src,
                           input logic [511:0] prior, input logic [15:0] mask);
        logic [511:0] exp;
        string tag_f, tag_m;
        exp = model(lsz, vl, men, mrg, bc, src, prior, mask);
        in_lsz = lsz; in_vl = vl; in_mask_en = men; in_merge = mrg; in_bcast = bc;
        in_src = src; in_prior = prior; in_mask = mask; in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        tag_f = bc ? "R9" : (lsz == 2'd1 ? "R3" : "R1");
        tag_m = !men ? "R7" : (mrg ? "R5" : "R6");
        check(out_valid && !out_err && out_data === exp,
              $sformatf("%s %s R4 lsz=%0d vl=%0d", tag_f, tag_m, lsz, vl), out_data, exp);
        if (!men)
            check(out_data[31:0] == 32'd0, "R2 lane0", {480'd0, out_data[31:0]}, '0);
        if (vl == 2'd0)
            check(out_data[511:128] == '0, "R8 upper", out_data, exp);
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [511:0] prior_v, ea, eb;
        for (int d = 0; d < 16; d++) prior_v[d*32+:32] = {16'hBEEF, 16'(d)};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && in_ready && out_data == '0 && !out_err, "R10 reset",
              out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int lsz = 0; lsz < 2; lsz++)
          for (int vl = 0; vl < 3; vl++)
            for (int men = 0; men < 2; men++)
              for (int mrg = 0; mrg < 2; mrg++)
                for (int bc = 0; bc < 2; bc++)
                  for (int p = 0; p < 7; p++)
                    for (int m = 0; m < 4; m++) begin
                        logic [15:0] mk;
                        mk = (m == 0) ? 16'hFFFF : (m == 1) ? 16'h0000 :
                             (m == 2) ? 16'hA5C3 : 16'h5A3C;
                        run_one(2'(lsz), 2'(vl), 1'(men), 1'(mrg), 1'(bc),
                                pattern(p), prior_v, mk);
                    end

        // R3: halves equal in low words only -> no 64-bit conflict
        ea = model(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, pattern(4), prior_v, 16'h0);
        check(ea == '0, "R3 model halves", ea, '0);

        // R11: unsupported codes
        for (int c = 0; c < 3; c++) begin
            in_lsz = (c == 0) ? 2'd2 : (c == 1) ? 2'd3 : 2'd0;
            in_vl  = (c == 2) ? 2'd3 : 2'd1;
            in_src = pattern(1); in_mask_en = 1'b0; in_bcast = 1'b0; in_valid = 1'b1;
            @(posedge clk);
            #1 in_valid = 1'b0;
            @(negedge clk);
            check(out_valid && out_err && out_data == '0, "R11 bad code", out_data, '0);
            @(posedge clk);
            #1;
        end

        // R10: stall with a waiting request, then REFILL on the same edge
        ea = model(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, pattern(2), prior_v, 16'h0);
        eb = model(2'd1, 2'd2, 1'b0, 1'b0, 1'b1, pattern(0), prior_v, 16'h0);
        out_ready = 1'b0;
        in_lsz = 2'd0; in_vl = 2'd2; in_mask_en = 1'b0; in_bcast = 1'b0;
        in_src = pattern(2); in_valid = 1'b1;
        @(posedge clk);
        #1 in_lsz = 2'd1; in_bcast = 1'b1; in_src = pattern(0);
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            check(out_valid && !in_ready && out_data === ea, "R10 stall hold", out_data, ea);
        end
        out_ready = 1'b1;
        @(negedge clk);
        check(out_valid && out_data === eb && !out_err, "R10 refill", out_data, eb);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!out_valid && in_ready, "R10 drain", {511'd0, out_valid}, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule